// File: doc/BRIEF.md
# Retention context save sequencer

This engine runs when a processor cluster is about to drop into a deep low-power state. It copies the interrupt-wakeup configuration from the always-on wakeup register block into an always-on retention RAM, so that boot code can rebuild that configuration after power returns. The copy follows a fixed order. For each enable bank it saves the per-CPU wakeup masks. It writes zero into the matching secure-mask slots, so that no secure interrupt comes back enabled. It then saves the auxiliary boot words and the sync-request mask and enable words. As its last step it sets a single "context valid" bit in a status word of the retention RAM, using a read-modify-write.

A low-power exit command clears that same bit with a read-modify-write. When the save-disable input is high, an enter command performs no access at all and only signals completion. Source register reads and RAM reads return data one cycle after the request. Every RAM access takes one cycle. All source and destination byte addresses are parameters.

Top module: `ctx_save_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `src_rd_en`, `ram_rd_en` and `ram_wr_en` are low.
- R2: For each bank b = 0..NBANK-1 (default 4), an accepted enter command copies the CPU0 mask and then the CPU1 mask. The source addresses are SRC_MASK_BASE+4b and SRC_MASK_BASE+SRC_CPU_STRIDE+4b (defaults 0x010 and 0x410+4b). Each word is written unchanged to DST_CPU0+4b or DST_CPU1+4b (defaults 0x100 and 0x110). The written value is the source data that returns one cycle after `src_rd_en`.
- R3: Straight after the two mask copies of bank b, the word 0 is written to DST_SEC0+4b and then to DST_SEC1+4b (defaults 0x120 and 0x130).
- R4: Once all banks are done, four copies follow in this order: auxiliary boot word 0 (0x800 to 0x140), auxiliary boot word 1 (0x804 to 0x144), sync-request mask (0xC08 to 0x148) and sync-request enable (0xC0C to 0x14C).
- R5: The last save step reads the status word at DST_STATUS (default 0x200) and writes it back with bit STATUS_BIT (default 3) set and every other bit unchanged. The read comes in the cycle just before the write, at the same address.
- R6: An exit command reads the status word and writes it back with bit STATUS_BIT cleared and every other bit unchanged. This is one RAM read, one RAM write, and no source read.
- R7: When `save_disable` is high, an enter command issues no source read, no RAM read and no RAM write. `done` rises at the same clock edge that samples the command.
- R8: Enter and exit commands that arrive while `busy` is high are ignored. They do not change the writes, the status word or the completion time.
- R9: `done` is high for exactly one cycle. It rises 6*NBANK+10 edges after the edge that samples an accepted enter command (34 by default), and 2 edges after an exit command.
- R10: When enter and exit arrive together while idle, the enter command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Low-power entry command (save) |
| exit_req | input | 1 | Low-power exit command (clear valid bit) |
| save_disable | input | 1 | Suppresses the save sequence |
| src_rd_en | output | 1 | Source register read strobe |
| src_rd_addr | output | 12 | Source register byte address |
| src_rd_data | input | 32 | Source read data, one cycle after the strobe |
| ram_rd_en | output | 1 | Retention RAM read strobe |
| ram_wr_en | output | 1 | Retention RAM write strobe |
| ram_addr | output | 12 | Retention RAM byte address |
| ram_wr_data | output | 32 | Retention RAM write data |
| ram_rd_data | input | 32 | Retention RAM read data, one cycle after the strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench logs every RAM write and compares the log, entry by entry, with the 21-step expected order. An engine that swapped the CPU0 and CPU1 copies, or that left the secure-mask slots unwritten or non-zero, shows up as an address or data mismatch at a known entry. The status word is preloaded with neighbouring bits set, so an engine that overwrote the word instead of patching one bit, or that patched the wrong bit, ends with the wrong value. Stray exit and enter pulses are injected in the middle of a save. A design that restarted, or that cleared the valid bit, would change the log length, the status word or the completion latency. Disabled saves, simultaneous commands, and an exit on a word whose bit is already clear cover the remaining corners.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

    localparam int CSS_AW = 12;
    localparam int CSS_DW = 32;

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_ZERO = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [CSS_AW-1:0] src;
        logic [CSS_AW-1:0] dst;
    } step_op_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    // four steps per bank, four trailing copies, one status update
    function automatic int save_step_count(input int nbank);
        return 4 * nbank + 5;
    endfunction

    function automatic logic [CSS_DW-1:0] patch_bit(
        input logic [CSS_DW-1:0] word,
        input int unsigned       idx,
        input logic              set_it
    );
        logic [CSS_DW-1:0] m;
        m      = '0;
        m[idx] = 1'b1;
        return set_it ? (word | m) : (word & ~m);
    endfunction

endpackage

// File: rtl/ctx_step_map.sv
module ctx_step_map import ctx_save_pkg::*; #(
    parameter int                NBANK          = 4,
    parameter int                STEP_W         = 5,
    parameter logic [CSS_AW-1:0] SRC_MASK_BASE  = 12'h010,
    parameter logic [CSS_AW-1:0] SRC_CPU_STRIDE = 12'h400,
    parameter logic [CSS_AW-1:0] SRC_AUX0       = 12'h800,
    parameter logic [CSS_AW-1:0] SRC_AUX1       = 12'h804,
    parameter logic [CSS_AW-1:0] SRC_SYNC_MASK  = 12'hC08,
    parameter logic [CSS_AW-1:0] SRC_SYNC_EN    = 12'hC0C,
    parameter logic [CSS_AW-1:0] DST_CPU0       = 12'h100,
    parameter logic [CSS_AW-1:0] DST_CPU1       = 12'h110,
    parameter logic [CSS_AW-1:0] DST_SEC0       = 12'h120,
    parameter logic [CSS_AW-1:0] DST_SEC1       = 12'h130,
    parameter logic [CSS_AW-1:0] DST_AUX0       = 12'h140,
    parameter logic [CSS_AW-1:0] DST_AUX1       = 12'h144,
    parameter logic [CSS_AW-1:0] DST_SYNC_MASK  = 12'h148,
    parameter logic [CSS_AW-1:0] DST_SYNC_EN    = 12'h14C,
    parameter logic [CSS_AW-1:0] DST_STATUS     = 12'h200
) (
    input  logic [STEP_W-1:0] step,
    input  logic              exit_mode,
    output step_op_t          op,
    output logic              last
);

    localparam int NSTEP      = save_step_count(NBANK);
    localparam int MASK_STEPS = 4 * NBANK;

    logic [CSS_AW-1:0] bank_off;
    logic [STEP_W-1:0] tail;

    always_comb begin
        bank_off = CSS_AW'({step >> 2, 2'b00});
        tail     = step - STEP_W'(MASK_STEPS);
        op.kind  = OP_ZERO;
        op.src   = '0;
        op.dst   = '0;
        if (exit_mode) begin
            op.kind = OP_CLR;
            op.dst  = DST_STATUS;
        end else if (int'(step) < MASK_STEPS) begin
            // R2 / R3: per-bank order CPU0 copy, CPU1 copy, secure zeros
            case (step[1:0])
                2'd0: begin
                    op.kind = OP_COPY;
                    op.src  = SRC_MASK_BASE + bank_off;
                    op.dst  = DST_CPU0 + bank_off;
                end
                2'd1: begin
                    op.kind = OP_COPY;
                    op.src  = SRC_MASK_BASE + SRC_CPU_STRIDE + bank_off;
                    op.dst  = DST_CPU1 + bank_off;
                end
                2'd2: begin
                    op.kind = OP_ZERO;
                    op.dst  = DST_SEC0 + bank_off;
                end
                default: begin
                    op.kind = OP_ZERO;
                    op.dst  = DST_SEC1 + bank_off;
                end
            endcase
        end else begin
            // R4 / R5: trailing copies, then the status update
            case (tail[2:0])
                3'd0: begin op.kind = OP_COPY; op.src = SRC_AUX0;      op.dst = DST_AUX0;      end
                3'd1: begin op.kind = OP_COPY; op.src = SRC_AUX1;      op.dst = DST_AUX1;      end
                3'd2: begin op.kind = OP_COPY; op.src = SRC_SYNC_MASK; op.dst = DST_SYNC_MASK; end
                3'd3: begin op.kind = OP_COPY; op.src = SRC_SYNC_EN;   op.dst = DST_SYNC_EN;   end
                default: begin op.kind = OP_SET; op.dst = DST_STATUS; end
            endcase
        end
        last = exit_mode || (int'(step) == NSTEP - 1);
    end

endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl import ctx_save_pkg::*; #(
    parameter int STEP_W     = 5,
    parameter int STATUS_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic              save_disable,
    input  step_op_t          op,
    input  logic              last,
    output logic [STEP_W-1:0] step,
    output logic              exit_mode,
    output logic              src_rd_en,
    output logic [CSS_AW-1:0] src_rd_addr,
    input  logic [CSS_DW-1:0] src_rd_data,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [CSS_AW-1:0] ram_addr,
    output logic [CSS_DW-1:0] ram_wr_data,
    input  logic [CSS_DW-1:0] ram_rd_data,
    output logic              busy,
    output logic              done
);

    seq_state_e state;
    logic       is_rmw;
    logic       step_fin;

    always_comb begin
        is_rmw      = (op.kind == OP_SET) || (op.kind == OP_CLR);
        step_fin    = (state == ST_WRITE) ||
                      (state == ST_ISSUE && op.kind == OP_ZERO);
        busy        = (state != ST_IDLE);
        src_rd_en   = (state == ST_ISSUE) && (op.kind == OP_COPY);
        src_rd_addr = op.src;
        ram_rd_en   = (state == ST_ISSUE) && is_rmw;
        ram_wr_en   = step_fin;
        ram_addr    = op.dst;
        ram_wr_data = '0;
        if (state == ST_WRITE) begin
            case (op.kind)
                OP_COPY: ram_wr_data = src_rd_data;
                OP_SET:  ram_wr_data = patch_bit(ram_rd_data, STATUS_BIT, 1'b1);
                OP_CLR:  ram_wr_data = patch_bit(ram_rd_data, STATUS_BIT, 1'b0);
                default: ram_wr_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= '0;
            exit_mode <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (enter_req) begin
                        if (save_disable) begin
                            done <= 1'b1;
                        end else begin
                            state     <= ST_ISSUE;
                            step      <= '0;
                            exit_mode <= 1'b0;
                        end
                    end else if (exit_req) begin
                        state     <= ST_ISSUE;
                        step      <= '0;
                        exit_mode <= 1'b1;
                    end
                end
                ST_ISSUE, ST_WRITE: begin
                    if (step_fin) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_ISSUE;
                            step  <= step + 1'b1;
                        end
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(src_rd_en || ram_rd_en || ram_wr_en)); // R7

    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (step == $past(step) || step == $past(step) + 1'b1)); // R8

    AST_RMW_PAIR: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en && state == ST_WRITE && is_rmw) |->
        ($past(ram_rd_en) && ram_addr == $past(ram_addr))); // R5

    AST_COPY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en && state == ST_WRITE && op.kind == OP_COPY) |-> $past(src_rd_en)); // R2

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq import ctx_save_pkg::*; #(
    parameter int                NBANK          = 4,
    parameter logic [CSS_AW-1:0] SRC_MASK_BASE  = 12'h010,
    parameter logic [CSS_AW-1:0] SRC_CPU_STRIDE = 12'h400,
    parameter logic [CSS_AW-1:0] SRC_AUX0       = 12'h800,
    parameter logic [CSS_AW-1:0] SRC_AUX1       = 12'h804,
    parameter logic [CSS_AW-1:0] SRC_SYNC_MASK  = 12'hC08,
    parameter logic [CSS_AW-1:0] SRC_SYNC_EN    = 12'hC0C,
    parameter logic [CSS_AW-1:0] DST_CPU0       = 12'h100,
    parameter logic [CSS_AW-1:0] DST_CPU1       = 12'h110,
    parameter logic [CSS_AW-1:0] DST_SEC0       = 12'h120,
    parameter logic [CSS_AW-1:0] DST_SEC1       = 12'h130,
    parameter logic [CSS_AW-1:0] DST_AUX0       = 12'h140,
    parameter logic [CSS_AW-1:0] DST_AUX1       = 12'h144,
    parameter logic [CSS_AW-1:0] DST_SYNC_MASK  = 12'h148,
    parameter logic [CSS_AW-1:0] DST_SYNC_EN    = 12'h14C,
    parameter logic [CSS_AW-1:0] DST_STATUS     = 12'h200,
    parameter int                STATUS_BIT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic              save_disable,
    output logic              src_rd_en,
    output logic [CSS_AW-1:0] src_rd_addr,
    input  logic [CSS_DW-1:0] src_rd_data,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [CSS_AW-1:0] ram_addr,
    output logic [CSS_DW-1:0] ram_wr_data,
    input  logic [CSS_DW-1:0] ram_rd_data,
    output logic              busy,
    output logic              done
);

    localparam int                STEP_W   = $clog2(save_step_count(NBANK));
    localparam logic [CSS_AW-1:0] SEC_SPAN = CSS_AW'(4 * NBANK);

    logic [STEP_W-1:0] step;
    logic              exit_mode;
    step_op_t          op;
    logic              last;

    ctx_step_map #(
        .NBANK(NBANK), .STEP_W(STEP_W),
        .SRC_MASK_BASE(SRC_MASK_BASE), .SRC_CPU_STRIDE(SRC_CPU_STRIDE),
        .SRC_AUX0(SRC_AUX0), .SRC_AUX1(SRC_AUX1),
        .SRC_SYNC_MASK(SRC_SYNC_MASK), .SRC_SYNC_EN(SRC_SYNC_EN),
        .DST_CPU0(DST_CPU0), .DST_CPU1(DST_CPU1),
        .DST_SEC0(DST_SEC0), .DST_SEC1(DST_SEC1),
        .DST_AUX0(DST_AUX0), .DST_AUX1(DST_AUX1),
        .DST_SYNC_MASK(DST_SYNC_MASK), .DST_SYNC_EN(DST_SYNC_EN),
        .DST_STATUS(DST_STATUS)
    ) map_i (
        .step(step), .exit_mode(exit_mode), .op(op), .last(last)
    );

    ctx_save_ctrl #(
        .STEP_W(STEP_W), .STATUS_BIT(STATUS_BIT)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .enter_req(enter_req), .exit_req(exit_req), .save_disable(save_disable),
        .op(op), .last(last), .step(step), .exit_mode(exit_mode),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
        .ram_wr_data(ram_wr_data), .ram_rd_data(ram_rd_data),
        .busy(busy), .done(done)
    );

    AST_SECURE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en &&
         ((ram_addr >= DST_SEC0 && ram_addr < DST_SEC0 + SEC_SPAN) ||
          (ram_addr >= DST_SEC1 && ram_addr < DST_SEC1 + SEC_SPAN)))
        |-> (ram_wr_data == '0)); // R3

    AST_ONE_RAM_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(ram_wr_en && ram_rd_en)); // R5

endmodule

// File: tb/ctx_save_seq_tb_top.sv
module ctx_save_seq_tb_top;
    import ctx_save_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enter_req = 1'b0;
    logic              exit_req = 1'b0;
    logic              save_disable = 1'b0;
    logic              src_rd_en;
    logic [CSS_AW-1:0] src_rd_addr;
    logic [CSS_DW-1:0] src_rd_data = '0;
    logic              ram_rd_en;
    logic              ram_wr_en;
    logic [CSS_AW-1:0] ram_addr;
    logic [CSS_DW-1:0] ram_wr_data;
    logic [CSS_DW-1:0] ram_rd_data = '0;
    logic              busy;
    logic              done;

    always #2 clk = ~clk;

    ctx_save_seq dut_i (
        .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
        .save_disable(save_disable), .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr),
        .src_rd_data(src_rd_data), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .ram_addr(ram_addr), .ram_wr_data(ram_wr_data), .ram_rd_data(ram_rd_data),
        .busy(busy), .done(done)
    );

    localparam logic [11:0] STATUS_ADDR = 12'h200;
    localparam int          NEXP = 21;
    // {kind(0 copy,1 zero,2 set), dst, src}
    localparam logic [25:0] EXP_TBL [NEXP] = '{
        {2'd0, 12'h100, 12'h010}, {2'd0, 12'h110, 12'h410}, {2'd1, 12'h120, 12'h000}, {2'd1, 12'h130, 12'h000},
        {2'd0, 12'h104, 12'h014}, {2'd0, 12'h114, 12'h414}, {2'd1, 12'h124, 12'h000}, {2'd1, 12'h134, 12'h000},
        {2'd0, 12'h108, 12'h018}, {2'd0, 12'h118, 12'h418}, {2'd1, 12'h128, 12'h000}, {2'd1, 12'h138, 12'h000},
        {2'd0, 12'h10C, 12'h01C}, {2'd0, 12'h11C, 12'h41C}, {2'd1, 12'h12C, 12'h000}, {2'd1, 12'h13C, 12'h000},
        {2'd0, 12'h140, 12'h800}, {2'd0, 12'h144, 12'h804}, {2'd0, 12'h148, 12'hC08}, {2'd0, 12'h14C, 12'hC0C},
        {2'd2, 12'h200, 12'h000}
    };

    logic [31:0] mem [1024];
    logic [11:0] log_a [64];
    logic [31:0] log_d [64];
    int log_n = 0, src_cnt = 0, rd_cnt = 0;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    function automatic logic [31:0] src_val(input logic [11:0] a);
        return {8'h5A, a, ~a};
    endfunction

    always @(posedge clk) begin
        if (src_rd_en) begin
            src_rd_data <= src_val(src_rd_addr);
            src_cnt     <= src_cnt + 1;
        end
        if (ram_rd_en) begin
            ram_rd_data <= mem[ram_addr[11:2]];
            rd_cnt      <= rd_cnt + 1;
        end
        if (ram_wr_en) begin
            mem[ram_addr[11:2]] <= ram_wr_data;
            if (log_n < 64) begin
                log_a[log_n] <= ram_addr;
                log_d[log_n] <= ram_wr_data;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_n = 0; src_cnt = 0; rd_cnt = 0;
    endtask

    // pulse command for one cycle, return edges from sampling edge to done
    task automatic run_cmd(input logic en, input logic ex, output int lat);
        @(negedge clk);
        enter_req = en; exit_req = ex;
        @(negedge clk);
        enter_req = 0; exit_req = 0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done width", {31'd0, done}, 32'd0);
    endtask

    task automatic check_save_log(input logic [31:0] status_before);
        logic [31:0] exp_d;
        check(log_n == NEXP, "R2 write count", log_n, NEXP);
        for (int i = 0; i < NEXP; i++) begin
            case (EXP_TBL[i][25:24])
                2'd0: exp_d = src_val(EXP_TBL[i][11:0]);
                2'd1: exp_d = 32'd0;
                default: exp_d = status_before | 32'h8;
            endcase
            check(log_a[i] == EXP_TBL[i][23:12],
                  EXP_TBL[i][25:24] == 2'd0 ? (i < 16 ? "R2 addr" : "R4 addr") :
                  EXP_TBL[i][25:24] == 2'd1 ? "R3 addr" : "R5 addr",
                  {20'd0, log_a[i]}, {20'd0, EXP_TBL[i][23:12]});
            check(log_d[i] == exp_d,
                  EXP_TBL[i][25:24] == 2'd0 ? (i < 16 ? "R2 data" : "R4 data") :
                  EXP_TBL[i][25:24] == 2'd1 ? "R3 data" : "R5 data",
                  log_d[i], exp_d);
        end
        check(src_cnt == 12, "R2 source reads", src_cnt, 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !src_rd_en && !ram_rd_en && !ram_wr_en, "R1 reset outputs",
              {27'd0, busy, done, src_rd_en, ram_rd_en, ram_wr_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !src_rd_en && !ram_rd_en && !ram_wr_en, "R1 after reset",
              {27'd0, busy, done, src_rd_en, ram_rd_en, ram_wr_en}, 32'd0);

        // normal save, table walk
        mem[STATUS_ADDR[11:2]] = 32'h8000_0041;
        clear_log();
        run_cmd(1'b1, 1'b0, lat);
        check(lat == 34, "R9 save latency", lat, 34);
        check_save_log(32'h8000_0041);
        check(mem[STATUS_ADDR[11:2]] == 32'h8000_0049, "R5 status set", mem[STATUS_ADDR[11:2]], 32'h8000_0049);

        // exit clears the bit
        clear_log();
        run_cmd(1'b0, 1'b1, lat);
        check(lat == 2, "R9 exit latency", lat, 2);
        check(log_n == 1 && rd_cnt == 1 && src_cnt == 0, "R6 exit accesses", log_n, 1);
        check(mem[STATUS_ADDR[11:2]] == 32'h8000_0041, "R6 status cleared", mem[STATUS_ADDR[11:2]], 32'h8000_0041);

        // exit with bit already clear, neighbours all set
        mem[STATUS_ADDR[11:2]] = 32'hFFFF_FFF7;
        clear_log();
        run_cmd(1'b0, 1'b1, lat);
        check(mem[STATUS_ADDR[11:2]] == 32'hFFFF_FFF7, "R6 others kept", mem[STATUS_ADDR[11:2]], 32'hFFFF_FFF7);

        // disabled save
        save_disable = 1'b1;
        mem[STATUS_ADDR[11:2]] = 32'h0000_0000;
        clear_log();
        run_cmd(1'b1, 1'b0, lat);
        check(lat == 0, "R7 disabled latency", lat, 0);
        check(log_n == 0 && src_cnt == 0 && rd_cnt == 0, "R7 no access", log_n + src_cnt + rd_cnt, 0);
        check(busy == 1'b0, "R7 not busy", {31'd0, busy}, 32'd0);
        check(mem[STATUS_ADDR[11:2]] == 32'd0, "R7 status untouched", mem[STATUS_ADDR[11:2]], 32'd0);
        save_disable = 1'b0;

        // commands while busy are ignored
        mem[STATUS_ADDR[11:2]] = 32'h0000_1000;
        clear_log();
        @(negedge clk);
        enter_req = 1'b1;
        @(negedge clk);
        enter_req = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            exit_req  = (lat == 5);
            enter_req = (lat == 12);
        end
        exit_req = 1'b0; enter_req = 1'b0;
        check(lat == 34, "R8 latency unchanged", lat, 34);
        repeat (20) @(negedge clk);
        check(log_n == NEXP, "R8 no restart", log_n, NEXP);
        check(mem[STATUS_ADDR[11:2]] == 32'h0000_1008, "R8 exit ignored", mem[STATUS_ADDR[11:2]], 32'h0000_1008);
        check(busy == 1'b0, "R8 idle after", {31'd0, busy}, 32'd0);

        // simultaneous enter and exit while idle
        mem[STATUS_ADDR[11:2]] = 32'h0000_0000;
        clear_log();
        run_cmd(1'b1, 1'b1, lat);
        check(lat == 34, "R10 save taken", lat, 34);
        check(log_n == NEXP, "R10 full sequence", log_n, NEXP);
        check(mem[STATUS_ADDR[11:2]] == 32'h0000_0008, "R10 status set", mem[STATUS_ADDR[11:2]], 32'h8);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule